// File: doc/BRIEF.md
# DMA Request Controller for a Card Data Buffer

This block drives an active-low DMA request line toward a host processor on behalf of a data buffer that sits between the host bus and a serial card link. A data command names a direction, either transmit (host to card) or receive (card to host), and a transfer length in words. Once the command has gone out to the card, the request asserts whenever the buffer needs more data from the host (transmit) or holds data for the host to take (receive).

A configuration input selects how the request behaves. With acknowledge counting off, the acknowledge pin has no effect. Each host access to the data word address pulls the request away, and the request may only come back four clocks later. With acknowledge counting on, every falling edge of the synchronized acknowledge pin counts one word. The request then stays asserted, whatever the buffer levels do, until the programmed length has been acknowledged.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset `dma_req_n` is 1, and it stays 1 whenever no command is in progress.
- R2: In a transmit command, `dma_req_n` is driven to 0 at the clock edge after `cmd_sent` when `tx_level` is below 2 bytes. It stays 1 while `tx_level` is 2 or more, and it stays 1 before `cmd_sent`.
- R3: In a receive command (`cmd_dir` = 1), `dma_req_n` is 0 while `rx_level` is nonzero after `cmd_sent`. It stays 1 before `cmd_sent`, even with data in the buffer.
- R4: In a receive command with acknowledge counting off, once `cmd_done` has been seen and `rx_level` is 0, the request goes to 1. It stays 1 even if `rx_level` becomes nonzero again, until a new command is issued.
- R5: With `cfg_ack_en` = 0, pulses on `ack_n` have no effect on `dma_req_n`.
- R6: With `cfg_ack_en` = 0, an access strobe whose `acc_addr` equals 3'b010 makes `dma_req_n` 1 for exactly the four clock edges after the access. It returns to 0 at the fifth edge if the request condition still holds. Accesses at any other address have no effect.
- R7: With `cfg_ack_en` = 1, once the request condition has been met, `dma_req_n` stays 0 regardless of buffer levels. It goes to 1 when the number of `ack_n` falling edges (after a two-stage synchronizer) equals `cmd_len`.
- R8: With `cfg_ack_en` = 1, data-address accesses do not drop the request.
- R9: A new `cmd_issue` reloads the remaining count from `cmd_len`, discards earlier acknowledges, and deasserts the request until the new `cmd_sent`.
- R10: `cmd_abort` forces `dma_req_n` to 1 at the next edge and clears the four-clock re-arm timer. A following command can therefore request without waiting out the old delay.
- R11: In a transmit command with acknowledge counting off, `cmd_done` ends the transfer: the request goes to 1 at the next edge and stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ack_en | input | 1 | 1: acknowledge-counted held request; 0: per-access drop |
| cmd_issue | input | 1 | Pulse: a new data command is issued |
| cmd_dir | input | 1 | Direction of the issued command, 0 transmit, 1 receive |
| cmd_len | input | LEN_W | Transfer length in words, loaded on `cmd_issue` |
| cmd_sent | input | 1 | Pulse: command has reached the card |
| cmd_done | input | 1 | Pulse: card reports the command complete |
| cmd_abort | input | 1 | Pulse: abandon the current command |
| tx_level | input | LVL_W | Bytes held in the transmit buffer (0 to 8) |
| rx_level | input | LVL_W | Bytes held in the receive buffer (0 to 8) |
| acc_strobe | input | 1 | Pulse: host access on the register bus |
| acc_addr | input | 3 | Word address of that access |
| ack_n | input | 1 | Asynchronous DMA acknowledge, active low |
| dma_req_n | output | 1 | DMA request, active low, registered |

## Verification
The situation that is hardest to reach is an abort that lands while the re-arm timer is still counting, followed quickly by a new command. Only then does a timer that survived the abort show up as a late request. The stimulus makes a data access, aborts on the next cycle, then issues and sends a new command inside the old four-clock window, and expects the request on the very next edge. The per-access delay is also exercised by a long stretch of random levels, random accesses and random addresses, checked every cycle against a cycle model in the bench.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/dma_ack_sync.sv
module dma_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic fall
);
    logic [STAGES:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-1:0], ack_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign fall = sync_q[STAGES] & ~sync_q[STAGES-1];

    // R7: one level change yields one counted edge
    a_r7_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/dma_rearm_timer.sv
module dma_rearm_timer #(
    parameter int REARM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load,
    output logic idle_next
);
    localparam int CW = $clog2(REARM + 1);
    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)               count_d = '0;
        else if (load)           count_d = CW'(REARM);
        else if (count_q != '0)  count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign idle_next = (count_d == '0);

    a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(REARM));
    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_q == '0));
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dma_req_pkg::*;
#(
    parameter int         LEN_W       = 8,
    parameter int         LVL_W       = 4,
    parameter int         TX_LOW      = 2,
    parameter int         REARM       = 4,
    parameter logic [2:0] DATA_ADDR   = 3'b010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ack_en,
    input  logic             cmd_issue,
    input  logic             cmd_dir,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_sent,
    input  logic             cmd_done,
    input  logic             cmd_abort,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             acc_strobe,
    input  logic [2:0]       acc_addr,
    input  logic             ack_n,
    output logic             dma_req_n
);
    localparam logic [LVL_W-1:0] TX_LOW_L = LVL_W'(TX_LOW);

    typedef struct packed {
        logic             active;
        xfer_dir_e        dir;
        logic             sent;
        logic             done;
        logic             hold;
        logic [LEN_W-1:0] remain;
        logic             req;
    } state_t;

    state_t s_d, s_q;
    logic   acc_hit, ack_fall, timer_idle, timer_load, base;

    assign acc_hit    = acc_strobe && (acc_addr == DATA_ADDR);
    assign timer_load = acc_hit && !cfg_ack_en;

    dma_ack_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ack_n (ack_n),
        .fall  (ack_fall)
    );

    dma_rearm_timer #(.REARM(REARM)) rearm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cmd_abort),
        .load      (timer_load),
        .idle_next (timer_idle)
    );

    always_comb begin
        s_d  = s_q;
        base = 1'b0;
        if (cmd_abort) begin
            s_d = '0;
        end else if (cmd_issue) begin
            s_d.active = 1'b1;
            s_d.dir    = xfer_dir_e'(cmd_dir);
            s_d.sent   = 1'b0;
            s_d.done   = 1'b0;
            s_d.hold   = 1'b0;
            s_d.remain = cmd_len;
            s_d.req    = 1'b0;
        end else begin
            s_d.sent = s_q.sent | (cmd_sent & s_q.active);
            s_d.done = s_q.done | (cmd_done & s_q.active);
            if (cfg_ack_en && ack_fall && (s_q.remain != '0))
                s_d.remain = s_q.remain - 1'b1;
            if (s_q.dir == DIR_RX) base = s_q.active && s_d.sent && (rx_level != '0);
            else                   base = s_q.active && s_d.sent && (tx_level < TX_LOW_L);
            if (!cfg_ack_en && s_d.done && ((s_q.dir == DIR_TX) || (rx_level == '0)))
                s_d.active = 1'b0;
            if (cfg_ack_en && s_q.hold && (s_d.remain == '0))
                s_d.active = 1'b0;
            s_d.hold = s_d.active && (s_d.remain != '0) && (s_q.hold || base);
            if (cfg_ack_en) s_d.req = s_d.hold;
            else            s_d.req = s_d.active && base && !acc_hit && timer_idle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dma_req_n = ~s_q.req;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && !cmd_issue) |=> dma_req_n);
    a_r6_access_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ack_en && acc_hit) |=> dma_req_n);
    a_r10_abort_drop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_abort |=> dma_req_n);
    a_r7_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ack_en && s_q.hold && (s_q.remain > 1) && !cmd_abort && !cmd_issue)
        |=> s_q.hold);
endmodule

// File: tb/dma_req_ctrl_tb_top.sv
module dma_req_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ack_en = 1'b0, cmd_issue = 1'b0, cmd_dir = 1'b0;
    logic [7:0] cmd_len = '0;
    logic       cmd_sent = 1'b0, cmd_done = 1'b0, cmd_abort = 1'b0;
    logic [3:0] tx_level = 4'd8, rx_level = 4'd0;
    logic       acc_strobe = 1'b0;
    logic [2:0] acc_addr = 3'b000;
    logic       ack_n = 1'b1;
    logic       dma_req_n;
    int         n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    dma_req_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ack_en(cfg_ack_en), .cmd_issue(cmd_issue),
        .cmd_dir(cmd_dir), .cmd_len(cmd_len), .cmd_sent(cmd_sent), .cmd_done(cmd_done),
        .cmd_abort(cmd_abort), .tx_level(tx_level), .rx_level(rx_level),
        .acc_strobe(acc_strobe), .acc_addr(acc_addr), .ack_n(ack_n), .dma_req_n(dma_req_n)
    );

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (dma_req_n !== exp) begin
            n_fail++;
            $display("FAIL %s: dma_req_n actual %b expected %b", tag, dma_req_n, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic pulse_issue(input logic dir, input logic [7:0] len);
        cmd_dir = dir; cmd_len = len; cmd_issue = 1'b1; step(); cmd_issue = 1'b0;
    endtask
    task automatic pulse_sent(); cmd_sent = 1'b1; step(); cmd_sent = 1'b0; endtask
    task automatic pulse_done(); cmd_done = 1'b1; step(); cmd_done = 1'b0; endtask
    task automatic pulse_abort(); cmd_abort = 1'b1; step(); cmd_abort = 1'b0; endtask
    task automatic access(input logic [2:0] a);
        acc_addr = a; acc_strobe = 1'b1; step(); acc_strobe = 1'b0;
    endtask
    task automatic ack_pulse();
        ack_n = 1'b0; repeat (2) step(); ack_n = 1'b1; repeat (3) step();
    endtask

    // bench model of the acknowledge-off request (R2, R3, R6)
    function automatic logic model_req(input logic rx, input logic [3:0] lvl,
                                       input logic hit, input int t_next);
        logic cond;
        cond = rx ? (lvl != 0) : (lvl < 2);
        return cond && !hit && (t_next == 0);
    endfunction

    task automatic random_phase(input logic rx, input int cycles);
        int t = 0;
        for (int i = 0; i < cycles; i++) begin
            logic [3:0] lvl;
            logic hit, exp;
            lvl = 4'($urandom_range(0, 8));
            if (rx) rx_level = lvl; else tx_level = lvl;
            acc_strobe = ($urandom_range(0, 2) == 0);
            acc_addr   = ($urandom_range(0, 1) == 0) ? 3'b010 : 3'($urandom_range(0, 7));
            hit = acc_strobe && (acc_addr == 3'b010);
            t = hit ? 4 : ((t > 0) ? t - 1 : 0);
            exp = model_req(rx, lvl, hit, t);
            step();
            chk(rx ? "R3/R6 random rx" : "R2/R6 random tx", !exp);
        end
        acc_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset", 1'b1);
        tx_level = 4'd0; rx_level = 4'd5; step();
        chk("R1 idle ignores levels", 1'b1);

        // R2 transmit, counting off
        pulse_issue(1'b0, 8'd4);
        step(); chk("R2 before sent", 1'b1);
        tx_level = 4'd8;
        pulse_sent(); chk("R2 enough data", 1'b1);
        tx_level = 4'd2; step(); chk("R2 level 2 enough", 1'b1);
        tx_level = 4'd1; step(); chk("R2 level 1 requests", 1'b0);

        // R6 per-access drop and four-clock re-arm
        access(3'b010); chk("R6 drop edge0", 1'b1);
        step(); chk("R6 drop edge1", 1'b1);
        step(); chk("R6 drop edge2", 1'b1);
        step(); chk("R6 drop edge3", 1'b1);
        step(); chk("R6 re-arm edge4", 1'b0);
        access(3'b011); chk("R6 other address ignored", 1'b0);

        // R5 acknowledge ignored when counting off
        ack_n = 1'b0;
        for (int i = 0; i < 3; i++) begin step(); chk("R5 ack low ignored", 1'b0); end
        ack_n = 1'b1;
        for (int i = 0; i < 3; i++) begin step(); chk("R5 ack high ignored", 1'b0); end

        // R11 transmit end on cmd_done
        pulse_done(); chk("R11 done ends tx", 1'b1);
        tx_level = 4'd0; step(); chk("R11 stays off", 1'b1);

        // R3 / R4 receive
        rx_level = 4'd4;
        pulse_issue(1'b1, 8'd4);
        step(); chk("R3 before sent", 1'b1);
        pulse_sent(); chk("R3 data present", 1'b0);
        rx_level = 4'd0; step(); chk("R3 empty", 1'b1);
        rx_level = 4'd3; step(); chk("R3 data again", 1'b0);
        pulse_done(); chk("R4 done but data left", 1'b0);
        rx_level = 4'd0; step(); chk("R4 drained ends", 1'b1);
        rx_level = 4'd6; step(); chk("R4 stays off after end", 1'b1);
        step(); chk("R4 stays off after end 2", 1'b1);

        // R7 / R8 acknowledge-counted hold
        cfg_ack_en = 1'b1; tx_level = 4'd0;
        pulse_issue(1'b0, 8'd3);
        pulse_sent(); chk("R7 starts", 1'b0);
        tx_level = 4'd8; step(); chk("R7 held despite level", 1'b0);
        access(3'b010); chk("R8 access no drop", 1'b0);
        step(); chk("R8 access no drop later", 1'b0);
        ack_pulse(); chk("R7 after 1 ack", 1'b0);
        ack_pulse(); chk("R7 after 2 acks", 1'b0);
        ack_pulse(); chk("R7 count reached", 1'b1);
        tx_level = 4'd0; step(); chk("R7 ended stays off", 1'b1);

        // R9 reload on new command
        pulse_issue(1'b0, 8'd5);
        pulse_sent(); chk("R9 first cmd", 1'b0);
        ack_pulse(); chk("R9 one ack", 1'b0);
        pulse_issue(1'b0, 8'd2); chk("R9 reissue drops", 1'b1);
        pulse_sent(); chk("R9 new cmd requests", 1'b0);
        ack_pulse(); chk("R9 after 1 of 2", 1'b0);
        ack_pulse(); chk("R9 after 2 of 2", 1'b1);

        // R10 abort clears re-arm timer
        cfg_ack_en = 1'b0; tx_level = 4'd0;
        pulse_issue(1'b0, 8'd4);
        pulse_sent(); chk("R10 setup", 1'b0);
        access(3'b010); chk("R10 access drop", 1'b1);
        pulse_abort(); chk("R10 abort off", 1'b1);
        pulse_issue(1'b0, 8'd4);
        pulse_sent(); chk("R10 no stale delay", 1'b0);
        pulse_abort(); chk("R10 abort while requesting", 1'b1);

        // random stretches, counting off
        pulse_issue(1'b0, 8'd9);
        tx_level = 4'd8; pulse_sent(); repeat (6) step();
        random_phase(1'b0, 400);
        pulse_abort();
        rx_level = 4'd0;
        pulse_issue(1'b1, 8'd9);
        pulse_sent(); repeat (6) step();
        random_phase(1'b1, 400);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule